// File: doc/BRIEF.md
# Register Write Record-and-Replay Buffer

This block sits between a host-facing serial target front end and a serial controller back end. During configuration the host issues a run of register writes. Each write has a 16-bit register address, which may be sparse, and a 16-bit value. The block keeps every write as one packed 32-bit entry in a single block-RAM-style memory, in arrival order. The memory only needs as many entries as registers actually written, so no table indexed by address is needed.

On a start request the block switches to its distribution phase. It walks the whole log once for every downstream device, from device 0 to device N-1. Each entry goes out on a valid/ready handshake together with the device index, and the controller engine then forwards the entry. When the last entry for the last device is accepted, a one-cycle done pulse follows and the block returns to idle. The log is kept, so a later start replays it again. A clear request empties the log so that a new capture session can begin.

Top module: `wrr_top`

## Requirements
- R1: A capture strobe (`cap_valid` high for one cycle while idle, with `clear` low) stores one entry and raises `entry_count` by one on the next cycle. The entry is the address in bits 31:16 and the data in bits 15:0.
- R2: A capture strobe while `entry_count` equals DEPTH is dropped. `entry_count` stays at DEPTH and `overflow` goes high and stays high until a clear.
- R3: After a start, entries go out for device 0, then device 1, and so on up to DEVICES-1. For each device, every stored entry goes out in capture order, with `rep_dev` holding the device index.
- R4: While `rep_valid` is high and `rep_ready` is low, `rep_valid`, `rep_dev`, `rep_addr` and `rep_data` hold their values.
- R5: `done` is high for exactly one cycle: the cycle after the last entry of the last device is accepted. `busy` is low on the cycle after that.
- R6: `start` has no effect while `busy` is high. The replay in progress continues unchanged and no second replay follows.
- R7: A replay keeps the log intact. A further start replays the same entries.
- R8: `clear` while idle sets `entry_count` to zero and lowers `overflow` on the next cycle. If `clear` and `cap_valid` arrive in the same cycle, `clear` wins.
- R9: While `busy` is high, both `clear` and `cap_valid` are ignored.
- R10: A start with an empty log gives `done` on the next cycle with `busy` high, and `rep_valid` never rises.
- R11: After reset, `entry_count`, `overflow`, `busy`, `done` and `rep_valid` are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cap_valid | input | 1 | Capture strobe from the target front end |
| cap_addr | input | 16 | Register address of the captured write |
| cap_data | input | 16 | Register value of the captured write |
| clear | input | 1 | Empty the log and drop the overflow flag |
| start | input | 1 | Begin replay to all devices |
| rep_valid | output | 1 | Replay entry presented |
| rep_ready | input | 1 | Controller back end accepts the entry |
| rep_dev | output | 2 | Target device index |
| rep_addr | output | 16 | Replayed register address |
| rep_data | output | 16 | Replayed register value |
| busy | output | 1 | Replay in progress |
| done | output | 1 | One-cycle end-of-replay pulse |
| overflow | output | 1 | Sticky flag: a capture was dropped |
| entry_count | output | 5 | Number of stored entries |

## Verification
A wrong write pointer shows up at once on `entry_count`, and on the first replay as missing, repeated or shifted entries. A fault in the read pointer or the device index breaks the order of address/value pairs or the `rep_dev` sequence within the first device pass. A bad end-of-pass decision shows in a handful of cycles: `done` comes too early or too late, or an extra pass appears. Stalls on `rep_ready` expose any read that changes an entry that has not yet been accepted.

// File: rtl/wrr_pkg.sv
package wrr_pkg;
  parameter int ADDR_W = 16;
  parameter int DATA_W = 16;
  localparam int ENTRY_W = ADDR_W + DATA_W;

  typedef struct packed {
    logic [ADDR_W-1:0] addr;
    logic [DATA_W-1:0] data;
  } entry_t;

  function automatic entry_t pack_entry(input logic [ADDR_W-1:0] a, input logic [DATA_W-1:0] d);
    entry_t e;
    e.addr = a;
    e.data = d;
    return e;
  endfunction

  // true when ptr designates the final stored entry of a log holding cnt entries
  function automatic logic is_final(input int unsigned ptr, input int unsigned cnt);
    return (ptr + 1) >= cnt;
  endfunction

  typedef enum logic [1:0] {SQ_IDLE, SQ_FETCH, SQ_SHOW, SQ_FIN} seq_state_t;
endpackage

// File: rtl/wrr_log_mem.sv
module wrr_log_mem #(
  parameter int WIDTH = 32,
  parameter int DEPTH = 16,
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic             clk,
  input  logic             we,
  input  logic [AW-1:0]    waddr,
  input  logic [WIDTH-1:0] wdata,
  input  logic             re,
  input  logic [AW-1:0]    raddr,
  output logic [WIDTH-1:0] rdata
);
  logic [WIDTH-1:0] store [DEPTH];

  always_ff @(posedge clk) begin
    if (we) store[waddr] <= wdata;
    if (re) rdata <= store[raddr];
  end
endmodule

// File: rtl/wrr_capture.sv
module wrr_capture
  import wrr_pkg::*;
#(
  parameter int DEPTH = 16,
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int CW = $clog2(DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cap_valid,
  input  logic [ADDR_W-1:0] cap_addr,
  input  logic [DATA_W-1:0] cap_data,
  input  logic              clear,
  input  logic              busy,
  output logic              mem_we,
  output logic [AW-1:0]     mem_waddr,
  output entry_t            mem_wdata,
  output logic [CW-1:0]     count,
  output logic              overflow
);
  logic full, clr_eff, cap_take, cap_accept, cap_drop;

  assign full       = (count == CW'(DEPTH));
  assign clr_eff    = clear && !busy;
  assign cap_take   = cap_valid && !busy && !clear;
  assign cap_accept = cap_take && !full;
  assign cap_drop   = cap_take && full;

  assign mem_we    = cap_accept;
  assign mem_waddr = AW'(count);
  assign mem_wdata = pack_entry(cap_addr, cap_data);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      count    <= '0;
      overflow <= 1'b0;
    end else if (clr_eff) begin
      count    <= '0;
      overflow <= 1'b0;
    end else begin
      if (cap_accept) count <= count + 1'b1;
      if (cap_drop) overflow <= 1'b1;
    end
  end

  a_r1_count_step: assert property (@(posedge clk) disable iff (!rst_n)
    cap_accept |=> count == $past(count) + 1'b1);
  a_r2_count_bound: assert property (@(posedge clk) disable iff (!rst_n)
    count <= CW'(DEPTH));
  a_r2_overflow_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (overflow && !clr_eff) |=> overflow);
  a_r8_clear_zero: assert property (@(posedge clk) disable iff (!rst_n)
    clr_eff |=> (count == '0) && !overflow);
  a_r9_busy_freeze: assert property (@(posedge clk) disable iff (!rst_n)
    busy |=> $stable(count));
endmodule

// File: rtl/wrr_sequencer.sv
module wrr_sequencer
  import wrr_pkg::*;
#(
  parameter int DEPTH   = 16,
  parameter int DEVICES = 3,
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int CW = $clog2(DEPTH + 1),
  localparam int DW = (DEVICES > 1) ? $clog2(DEVICES) : 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic [CW-1:0] count,
  output logic          rd_en,
  output logic [AW-1:0] rd_ptr,
  output logic          rep_valid,
  input  logic          rep_ready,
  output logic [DW-1:0] rep_dev,
  output logic          busy,
  output logic          done
);
  seq_state_t state;
  logic start_go, entry_accept, last_entry, last_dev, last_accept;

  assign start_go     = start && (state == SQ_IDLE);
  assign entry_accept = (state == SQ_SHOW) && rep_ready;
  assign last_entry   = is_final(int'(rd_ptr), int'(count));
  assign last_dev     = (rep_dev == DW'(DEVICES - 1));
  assign last_accept  = entry_accept && last_entry && last_dev;

  assign rd_en     = (state == SQ_FETCH);
  assign rep_valid = (state == SQ_SHOW);
  assign busy      = (state != SQ_IDLE);
  assign done      = (state == SQ_FIN);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state   <= SQ_IDLE;
      rd_ptr  <= '0;
      rep_dev <= '0;
    end else begin
      unique case (state)
        SQ_IDLE: if (start_go) begin
          rd_ptr  <= '0;
          rep_dev <= '0;
          state   <= (count == '0) ? SQ_FIN : SQ_FETCH;
        end
        SQ_FETCH: state <= SQ_SHOW;
        SQ_SHOW: if (entry_accept) begin
          if (!last_entry) begin
            rd_ptr <= rd_ptr + 1'b1;
            state  <= SQ_FETCH;
          end else if (!last_dev) begin
            rd_ptr  <= '0;
            rep_dev <= rep_dev + 1'b1;
            state   <= SQ_FETCH;
          end else begin
            state <= SQ_FIN;
          end
        end
        SQ_FIN: state <= SQ_IDLE;
        default: state <= SQ_IDLE;
      endcase
    end
  end

  a_r4_hold_stable: assert property (@(posedge clk) disable iff (!rst_n)
    (rep_valid && !rep_ready) |=> rep_valid && $stable(rep_dev) && $stable(rd_ptr));
  a_r5_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done && !busy);
  a_r5_done_after_last: assert property (@(posedge clk) disable iff (!rst_n)
    last_accept |=> done);
  a_r6_busy_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !done) |=> busy);
  a_r3_dev_range: assert property (@(posedge clk) disable iff (!rst_n)
    rep_valid |-> (rep_dev < DW'(DEVICES)));
  a_r10_empty_no_valid: assert property (@(posedge clk) disable iff (!rst_n)
    (start_go && count == '0) |=> done && !rep_valid);
endmodule

// File: rtl/wrr_top.sv
module wrr_top
  import wrr_pkg::*;
#(
  parameter int DEPTH   = 16,
  parameter int DEVICES = 3,
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int CW = $clog2(DEPTH + 1),
  localparam int DW = (DEVICES > 1) ? $clog2(DEVICES) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cap_valid,
  input  logic [ADDR_W-1:0] cap_addr,
  input  logic [DATA_W-1:0] cap_data,
  input  logic              clear,
  input  logic              start,
  output logic              rep_valid,
  input  logic              rep_ready,
  output logic [DW-1:0]     rep_dev,
  output logic [ADDR_W-1:0] rep_addr,
  output logic [DATA_W-1:0] rep_data,
  output logic              busy,
  output logic              done,
  output logic              overflow,
  output logic [CW-1:0]     entry_count
);
  logic          mem_we, mem_re;
  logic [AW-1:0] mem_waddr, mem_raddr;
  entry_t        mem_wdata, mem_rdata;

  wrr_capture #(.DEPTH(DEPTH)) u_capture (
    .clk(clk), .rst_n(rst_n), .cap_valid(cap_valid), .cap_addr(cap_addr),
    .cap_data(cap_data), .clear(clear), .busy(busy), .mem_we(mem_we),
    .mem_waddr(mem_waddr), .mem_wdata(mem_wdata), .count(entry_count),
    .overflow(overflow)
  );

  wrr_log_mem #(.WIDTH(ENTRY_W), .DEPTH(DEPTH)) u_mem (
    .clk(clk), .we(mem_we), .waddr(mem_waddr), .wdata(mem_wdata),
    .re(mem_re), .raddr(mem_raddr), .rdata(mem_rdata)
  );

  wrr_sequencer #(.DEPTH(DEPTH), .DEVICES(DEVICES)) u_seq (
    .clk(clk), .rst_n(rst_n), .start(start), .count(entry_count),
    .rd_en(mem_re), .rd_ptr(mem_raddr), .rep_valid(rep_valid),
    .rep_ready(rep_ready), .rep_dev(rep_dev), .busy(busy), .done(done)
  );

  assign rep_addr = mem_rdata.addr;
  assign rep_data = mem_rdata.data;

  a_r4_payload_stable: assert property (@(posedge clk) disable iff (!rst_n)
    (rep_valid && !rep_ready) |=> $stable(rep_addr) && $stable(rep_data));
  a_r9_no_write_busy: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> !mem_we);
endmodule

// File: tb/test_wrr_top.sv
module test_wrr_top;
  localparam int PERIOD = 10;
  localparam int DEPTH  = 16;
  localparam int NDEV   = 3;
  localparam int NVEC   = 6;
  // stimulus table: {address, value}; replay expects the same pairs in this order
  localparam logic [31:0] VEC [NVEC] = '{
    32'hA000_1234, 32'h0004_BEEF, 32'hFFFF_0001,
    32'h0004_CAFE, 32'h7F10_0000, 32'h1200_5A5A };

  logic clk = 0, rst_n = 0;
  logic cap_valid = 0, clear = 0, start = 0, rep_ready = 0;
  logic [15:0] cap_addr = 0, cap_data = 0;
  logic rep_valid, busy, done, overflow;
  logic [1:0] rep_dev;
  logic [15:0] rep_addr, rep_data;
  logic [4:0] entry_count;

  int total = 0, bad = 0;
  logic [31:0] exp_log [32];
  int exp_n = 0;
  bit finished = 0;

  always #(PERIOD/2) clk = ~clk;

  wrr_top #(.DEPTH(DEPTH), .DEVICES(NDEV)) i_wrr_top (
    .clk(clk), .rst_n(rst_n), .cap_valid(cap_valid), .cap_addr(cap_addr),
    .cap_data(cap_data), .clear(clear), .start(start), .rep_valid(rep_valid),
    .rep_ready(rep_ready), .rep_dev(rep_dev), .rep_addr(rep_addr),
    .rep_data(rep_data), .busy(busy), .done(done), .overflow(overflow),
    .entry_count(entry_count)
  );

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic capture(input logic [31:0] e);
    cap_valid = 1; cap_addr = e[31:16]; cap_data = e[15:0];
    @(negedge clk);
    cap_valid = 0;
  endtask

  task automatic do_clear();
    clear = 1; @(negedge clk); clear = 0;
    exp_n = 0;
  endtask

  // replay checker; stall holds ready low on the first entry of each device,
  // poke drives start/clear/cap_valid during that stall
  task automatic replay(input bit stall, input bit poke);
    start = 1; @(negedge clk); start = 0;
    for (int d = 0; d < NDEV; d++) begin
      for (int i = 0; i < exp_n; i++) begin
        int t = 0;
        while (!rep_valid && t < 20) begin @(negedge clk); t++; end
        chk(rep_valid, "R3 valid", rep_valid, 1);
        chk(rep_dev == d, "R3 dev", rep_dev, d);
        chk({rep_addr, rep_data} == exp_log[i], "R3 entry", {rep_addr, rep_data}, exp_log[i]);
        if (stall && i == 0) begin
          if (poke) begin start = 1; clear = 1; cap_valid = 1; cap_addr = 16'hDEAD; cap_data = 16'hDEAD; end
          repeat (2) @(negedge clk);
          start = 0; clear = 0; cap_valid = 0;
          chk(rep_valid && rep_dev == d && {rep_addr, rep_data} == exp_log[i],
              "R4 stall hold", {rep_addr, rep_data}, exp_log[i]);
        end
        rep_ready = 1; @(negedge clk); rep_ready = 0;
        if (d == NDEV-1 && i == exp_n-1) chk(done == 1, "R5 done after last", done, 1);
        else chk(done == 0, "R5 no early done", done, 0);
      end
    end
    if (exp_n == 0) begin
      chk(done && busy && !rep_valid, "R10 empty done", {done, busy, rep_valid}, 3'b110);
    end
    @(negedge clk);
    chk(!done && !busy, "R5 pulse end", {done, busy}, 0);
    repeat (3) @(negedge clk);
    chk(!rep_valid && !busy, "R6 no second replay", {rep_valid, busy}, 0);
  endtask

  initial begin
    #(PERIOD * 150000);
    if (!finished) begin
      total++; bad++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk(entry_count == 0 && !overflow && !busy && !done && !rep_valid, "R11 reset",
        {entry_count, overflow, busy, done, rep_valid}, 0);

    // table walk: capture each vector and check the count step (R1)
    for (int k = 0; k < NVEC; k++) begin
      capture(VEC[k]);
      exp_log[exp_n] = VEC[k]; exp_n++;
      chk(entry_count == exp_n, "R1 count", entry_count, exp_n);
    end
    replay(0, 0);                       // R3 plain order
    replay(1, 1);                       // R4 stall, R6/R9 pokes ignored
    chk(entry_count == NVEC, "R9 count kept", entry_count, NVEC);
    replay(0, 0);                       // R7 log intact after replays

    // R8 clear wins over capture
    cap_valid = 1; cap_addr = 16'h1111; cap_data = 16'h2222; clear = 1;
    @(negedge clk);
    cap_valid = 0; clear = 0; exp_n = 0;
    chk(entry_count == 0, "R8 clear wins", entry_count, 0);
    replay(0, 0);                       // R10 empty start

    // R2 overflow: DEPTH+1 captures
    for (int k = 0; k <= DEPTH; k++) begin
      logic [31:0] e;
      e = {16'h3000 + 16'(k * 7), 16'h0100 + 16'(k)};
      capture(e);
      if (k < DEPTH) begin exp_log[exp_n] = e; exp_n++; end
    end
    chk(entry_count == DEPTH, "R2 count full", entry_count, DEPTH);
    chk(overflow == 1, "R2 overflow set", overflow, 1);
    capture(32'h5555_6666);
    chk(overflow == 1 && entry_count == DEPTH, "R2 sticky", {overflow, entry_count}, {1'b1, 5'd16});
    replay(1, 0);                       // dropped entries absent
    chk(overflow == 1, "R2 sticky after replay", overflow, 1);
    do_clear();
    chk(entry_count == 0 && overflow == 0, "R8 clear", {entry_count, overflow}, 0);

    finished = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule